// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block gathers 256 level-sensitive interrupt lines, arranged as 32 groups of 8, into one level interrupt per group for an upstream interrupt controller. Each source passes through a two-flop synchronizer. It is then gated by its own enable bit, and the enabled lines of each group are OR-reduced into a registered group output. A summary word gives software a single view of which groups are asserting.

Software reaches the block through a single-cycle strobe port. Enables are never written directly. One word per four groups sets enable bits for every 1 written, and a companion word clears enable bits for every 1 written. Each set of four groups also exposes its synchronized raw levels and its masked levels. Four groups share one 32-bit word, and group g occupies bits (g mod 4)*8 upward of word index g/4. The four registers of word index n sit at byte addresses 0x10*n + {0x0 set, 0x4 clear, 0x8 raw, 0xC masked}, and the group summary sits at 0x100.

Top module: `grp_irq_combiner`

## Requirements
- R1: Source s belongs to group s/8 at position s%8. The raw word at 0x10*n+0x8 shows, in bits (g mod 4)*8+k, the level of source 8*g+k for g in 4n..4n+3, two clock edges after the input changes.
- R2: A write to 0x10*n+0x0 sets every enable bit of word n whose data bit is 1 and leaves the bits written 0 unchanged, effective at that clock edge.
- R3: A write to 0x10*n+0x4 clears every enable bit of word n whose data bit is 1 and leaves the other bits unchanged.
- R4: A read of either 0x10*n+0x0 or 0x10*n+0x4 returns the current enable word n.
- R5: A read of 0x10*n+0xC returns raw word n ANDed with enable word n.
- R6: Group output g is high one clock after its synchronized sources ANDed with their enables become non-zero, and it drops one clock after they all become zero.
- R7: Bit g of the word read at 0x100 equals group output g.
- R8: Writes to raw (0x8) and masked (0xC) offsets, to 0x100, to misaligned addresses and to unmapped addresses leave all enable bits unchanged.
- R9: Reads of unmapped or misaligned addresses return zero, and the read data bus is zero whenever no read strobe is given.
- R10: After reset every enable bit is 0 and all group outputs and summary bits are 0, even with every source asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_lvl_i | input | 256 | Level interrupt sources, group-major |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr_i | input | 9 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when no read is made |
| grp_irq_o | output | 32 | One level interrupt per group |

## Verification
The bound checker watches every cycle for the enable update rules: set bits rise and clear bits fall after the matching write, and enables do not move without such a write. It also checks that each group output tracks the previous cycle's masked group activity, and that unmapped or idle reads return zero. Whether a given source lands in the right group and bit position can only be shown by the bench. So can the two-stage latency from pin to raw status and the composed masked and summary read-back. The bench sweeps every one of the 256 sources and a set of rotated enable patterns for these.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  // Register kind within a word's 16-byte slot, decoded from address bits [3:2].
  typedef enum logic [1:0] {
    SEL_EN_SET = 2'd0,
    SEL_EN_CLR = 2'd1,
    SEL_RAW    = 2'd2,
    SEL_MASKED = 2'd3
  } word_sel_e;

  localparam int unsigned SLOT_BYTES  = 16;
  localparam int unsigned PEND_OFFSET = 'h100;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_stb_i,
  input  logic                        clr_stb_i,
  input  logic [IDX_W-1:0]            word_idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_WORDS*DATA_W-1:0] en_o
);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic              hit;
    logic              en_ce;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] en_d;
    logic [DATA_W-1:0] en_q;

    always_comb begin
      hit      = (word_idx_i == IDX_W'(w));
      set_mask = (set_stb_i && hit) ? wdata_i : '0;
      clr_mask = (clr_stb_i && hit) ? wdata_i : '0;
      en_ce    = (set_stb_i || clr_stb_i) && hit;
      // clear wins over set for the same bit
      en_d     = (en_q | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= '0;
      end else if (en_ce) begin
        en_q <= en_d;
      end
    end

    assign en_o[w*DATA_W +: DATA_W] = en_q;
  end

endmodule

// File: rtl/irq_group_reduce.sv
module irq_group_reduce #(
  parameter int NUM_GROUPS = 32,
  parameter int GROUP_W    = 8,
  localparam int NUM_SRC   = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    raw_i,
  input  logic [NUM_SRC-1:0]    en_i,
  output logic [NUM_GROUPS-1:0] grp_o
);

  logic [NUM_GROUPS-1:0] grp_d;
  logic [NUM_GROUPS-1:0] grp_q;
  logic                  grp_ce;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_d[g] = |(raw_i[g*GROUP_W +: GROUP_W] & en_i[g*GROUP_W +: GROUP_W]);
  end

  assign grp_ce = (grp_d != grp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (grp_ce) begin
      grp_q <= grp_d;
    end
  end

  assign grp_o = grp_q;

endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS = 32,
  parameter int GROUP_W    = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 9,
  localparam int NUM_SRC   = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_lvl_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic [NUM_GROUPS-1:0] grp_irq_o
);

  localparam int GRP_PER_WORD = DATA_W / GROUP_W;
  localparam int NUM_WORDS    = NUM_GROUPS / GRP_PER_WORD;
  localparam int IDX_W        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [ADDR_W:0]   WIN_END   = (ADDR_W+1)'(NUM_WORDS * SLOT_BYTES);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(PEND_OFFSET);

  logic [NUM_SRC-1:0] raw_flat;
  logic [NUM_SRC-1:0] en_flat;
  logic [DATA_W-1:0]  raw_w [NUM_WORDS];
  logic [DATA_W-1:0]  en_w  [NUM_WORDS];

  logic              win_hit;
  logic              pend_hit;
  logic [IDX_W-1:0]  word_idx;
  word_sel_e         sel;
  logic              set_stb;
  logic              clr_stb;
  logic [DATA_W-1:0] rdata_d;

  // address decode
  always_comb begin
    win_hit  = ({1'b0, bus_addr_i} < WIN_END) && (bus_addr_i[1:0] == 2'b00);
    pend_hit = (bus_addr_i == PEND_ADDR);
    word_idx = bus_addr_i[IDX_W+3:4];
    sel      = word_sel_e'(bus_addr_i[3:2]);
    set_stb  = bus_wr_i && win_hit && (sel == SEL_EN_SET);
    clr_stb  = bus_wr_i && win_hit && (sel == SEL_EN_CLR);
  end

  irq_src_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_lvl_i),
    .sync_o  (raw_flat)
  );

  irq_enable_bank #(
    .NUM_WORDS (NUM_WORDS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
  ) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_stb_i  (set_stb),
    .clr_stb_i  (clr_stb),
    .word_idx_i (word_idx),
    .wdata_i    (bus_wdata_i),
    .en_o       (en_flat)
  );

  irq_group_reduce #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
  ) u_red (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (raw_flat),
    .en_i  (en_flat),
    .grp_o (grp_irq_o)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_view
    assign raw_w[w] = raw_flat[w*DATA_W +: DATA_W];
    assign en_w[w]  = en_flat[w*DATA_W +: DATA_W];
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    if (bus_rd_i) begin
      if (win_hit) begin
        unique case (sel)
          SEL_EN_SET,
          SEL_EN_CLR: rdata_d = en_w[word_idx];
          SEL_RAW:    rdata_d = raw_w[word_idx];
          SEL_MASKED: rdata_d = raw_w[word_idx] & en_w[word_idx];
          default:    rdata_d = '0;
        endcase
      end else if (pend_hit) begin
        rdata_d[NUM_GROUPS-1:0] = grp_irq_o;
      end
    end
  end

  assign bus_rdata_o = rdata_d;

endmodule

// File: rtl/irq_comb_chk.sv
module irq_comb_chk #(
  parameter int NUM_GROUPS = 32,
  parameter int GROUP_W    = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 9,
  localparam int NUM_SRC   = NUM_GROUPS * GROUP_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr,
  input logic                  rd,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     wdata,
  input logic [DATA_W-1:0]     rdata,
  input logic [NUM_SRC-1:0]    en_flat,
  input logic [NUM_SRC-1:0]    raw_flat,
  input logic [NUM_GROUPS-1:0] grp_irq
);

  localparam int NUM_WORDS = NUM_GROUPS / (DATA_W / GROUP_W);

  logic mapped;
  logic en_write;
  always_comb begin
    mapped   = ((int'(addr) < NUM_WORDS * 16) && (addr[1:0] == 2'b00)) ||
               (int'(addr) == 'h100);
    en_write = wr && (int'(addr) < NUM_WORDS * 16) && (addr[1:0] == 2'b00) &&
               (addr[3] == 1'b0);
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(w*16)) |=>
      ((en_flat[w*DATA_W +: DATA_W] & $past(wdata)) == $past(wdata)));
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(w*16 + 4)) |=>
      ((en_flat[w*DATA_W +: DATA_W] & $past(wdata)) == '0));
  end

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_write |=> (en_flat == $past(en_flat)));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_g
    assert_grp_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_flat[g*GROUP_W +: GROUP_W] & en_flat[g*GROUP_W +: GROUP_W]) != '0) |=> grp_irq[g]);
    assert_grp_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_flat[g*GROUP_W +: GROUP_W] & en_flat[g*GROUP_W +: GROUP_W]) == '0) |=> !grp_irq[g]);
  end

  assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |-> (rdata == '0));
  assert_idle_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R10: assert (en_flat == '0 && grp_irq == '0);
    end
  end

endmodule

bind grp_irq_combiner irq_comb_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_W    (GROUP_W),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (bus_wr_i),
  .rd       (bus_rd_i),
  .addr     (bus_addr_i),
  .wdata    (bus_wdata_i),
  .rdata    (bus_rdata_o),
  .en_flat  (en_flat),
  .raw_flat (raw_flat),
  .grp_irq  (grp_irq_o)
);

// File: tb/grp_irq_combiner_tb.sv
module grp_irq_combiner_tb;

  localparam int NG = 32;
  localparam int GW = 8;
  localparam int NS = NG * GW;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NS-1:0] src = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NG-1:0] grp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] en_m [NW];

  always #2 clk = ~clk;

  grp_irq_combiner u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl_i   (src),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .grp_irq_o   (grp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  // called at a negedge; data is combinational
  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0; addr = '0;
  endtask

  function automatic logic [NG-1:0] exp_grp(input logic [NS-1:0] s);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g] = |(s[g*GW +: GW] & en_m[g/4][(g%4)*8 +: 8]);
    return r;
  endfunction

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk);
    src = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [NS-1:0] pat;
    for (int w = 0; w < NW; w++) en_m[w] = '0;

    // R10: reset with all sources high
    src = '1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 grp after reset", grp, '0);
    bus_read(9'h100, d); chk("R10 pending after reset", d, '0);
    for (int w = 0; w < NW; w++) begin
      bus_read(9'(w*16), d); chk("R10 enable after reset", d, '0);
    end

    // R2/R4: enable everything, read back through set and clear offsets
    for (int w = 0; w < NW; w++) begin
      bus_write(9'(w*16), 32'hFFFF_FFFF);
      en_m[w] = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      bus_read(9'(w*16), d);     chk("R4 set offset readback", d, en_m[w]);
      bus_read(9'(w*16 + 4), d); chk("R4 clr offset readback", d, en_m[w]);
    end

    // R1/R5/R6/R7: sweep each source alone
    for (int s = 0; s < NS; s++) begin
      pat = '0; pat[s] = 1'b1;
      set_src(pat);
      chk("R6 single source group", grp, 32'(1) << (s/8));
      bus_read(9'((s/32)*16 + 8), d);  chk("R1 raw position", d, 32'(1) << (s%32));
      bus_read(9'((s/32)*16 + 12), d); chk("R5 masked position", d, 32'(1) << (s%32));
      bus_read(9'h100, d);             chk("R7 pending position", d, 32'(1) << (s/8));
    end

    // R3: clear everything
    set_src('0);
    for (int w = 0; w < NW; w++) begin
      bus_write(9'(w*16 + 4), 32'hFFFF_FFFF);
      en_m[w] = '0;
      bus_read(9'(w*16), d); chk("R3 full clear", d, 32'h0);
    end

    // R2: zero bits leave enables unchanged
    bus_write(9'h020, 32'h0000_00F0);
    bus_write(9'h020, 32'h0000_0003);
    en_m[2] = 32'h0000_00F3;
    bus_read(9'h020, d); chk("R2 accumulate set", d, 32'h0000_00F3);
    bus_write(9'h024, 32'h0000_0010);
    en_m[2] = 32'h0000_00E3;
    bus_read(9'h024, d); chk("R3 partial clear", d, 32'h0000_00E3);

    // R3/R6: clearing enable with source active drops group one clock later
    set_src('1);
    chk("R6 group 8 high", grp, exp_grp('1));
    bus_write(9'h024, 32'h0000_00FF);
    en_m[2] = '0;
    @(negedge clk);
    chk("R3 group drops after clear", grp, '0);

    // R6: source deassert drops group
    bus_write(9'h000, 32'h0000_0001);
    en_m[0] = 32'h0000_0001;
    set_src(256'h1);
    chk("R6 group0 on", grp, 32'h1);
    set_src('0);
    chk("R6 group0 off", grp, 32'h0);

    // R8: writes to status, summary, unmapped, misaligned are ignored
    bus_write(9'h038, 32'hFFFF_FFFF);
    bus_write(9'h03C, 32'hFFFF_FFFF);
    bus_write(9'h100, 32'hFFFF_FFFF);
    bus_write(9'h080, 32'hFFFF_FFFF);
    bus_write(9'h1F0, 32'hFFFF_FFFF);
    bus_write(9'h011, 32'hFFFF_FFFF);
    for (int w = 0; w < NW; w++) begin
      bus_read(9'(w*16), d); chk("R8 enables untouched", d, en_m[w]);
    end

    // R9: unmapped, misaligned and idle reads
    set_src('1);
    bus_read(9'h080, d); chk("R9 unmapped 0x80", d, '0);
    bus_read(9'h104, d); chk("R9 unmapped 0x104", d, '0);
    bus_read(9'h1FC, d); chk("R9 unmapped 0x1FC", d, '0);
    bus_read(9'h009, d); chk("R9 misaligned 0x09", d, '0);
    addr = 9'h008; #1 chk("R9 idle read bus", rdata, '0); addr = '0;

    // R5/R6/R7: rotated enable patterns across all words
    for (int r = 0; r < 4; r++) begin
      for (int w = 0; w < NW; w++) begin
        bus_write(9'(w*16 + 4), 32'hFFFF_FFFF);
        en_m[w] = {32'hA5C3_0F96 << ((w + r) % 32)} | (32'hA5C3_0F96 >> (32 - ((w + r) % 32)) & {32{((w+r)%32) != 0}});
        bus_write(9'(w*16), en_m[w]);
      end
      for (int s = 0; s < NS; s++) pat[s] = ((s * 7 + r * 13) % 5) == 0;
      set_src(pat);
      chk("R6 pattern groups", grp, exp_grp(pat));
      bus_read(9'h100, d); chk("R7 pattern pending", d, exp_grp(pat));
      for (int w = 0; w < NW; w++) begin
        bus_read(9'(w*16 + 12), d); chk("R5 pattern masked", d, pat[w*32 +: 32] & en_m[w]);
        bus_read(9'(w*16 + 8), d);  chk("R1 pattern raw", d, pat[w*32 +: 32]);
      end
    end

    finish_run();
  end

endmodule